// File: doc/BRIEF.md
# Shared Semaphore Flag Unit

This block holds a small bank of one-bit interlock flags that several processors share. Cooperating processors use them to guard regions of shared memory. A processor never names a flag in its request. Each processor has a selection register, loaded by supervisor software through its own write port, and every flag operation from that processor acts on the flag that register names.

Four operations exist: read the flag, force it to 1, force it to 0, and an atomic test-and-set. Test-and-set returns the previous value and leaves the flag at 1. A returned 0 means the caller now holds the lock. Any number of processors may issue in the same cycle. Requests to the same flag are serialized inside that cycle in ascending processor index, so every request sees the updates of the lower-indexed ones. Requests to different flags do not interact.

Each request gets a response pulse one cycle later, carrying the flag value the request observed. The caller uses that value for its branch decision.

Top module: `sema_interlock`

## Requirements
- R1: While reset is asserted, all flags become 0, every selection register becomes 0 and no response is valid. After reset, a TEST from every processor returns 0.
- R2: When selWrEn[p] is high at a clock edge, selection register p loads selWrData[p*3 +: 3]. The new value governs operations from the next cycle on. An operation issued in the same cycle as the load uses the old selection.
- R3: Operation codes in opCode[p*2 +: 2] are 0 TEST, 1 SET, 2 CLEAR and 3 TESTSET. A SET leaves the selected flag at 1.
- R4: A CLEAR leaves the selected flag at 0.
- R5: A TEST returns the selected flag's value and does not change it.
- R6: A TESTSET returns the value the flag held before the request and leaves the flag at 1 in the same cycle. A returned 0 means the lock was acquired.
- R7: rspValid[p] is high for exactly the one cycle that follows a cycle with opValid[p] high. rspBit[p] is 0 whenever rspValid[p] is 0.
- R8: rspBit[p] carries the selected flag's value after the updates of all lower-indexed processors in the same cycle and before processor p's own update. SET and CLEAR also return this value.
- R9: When several processors act on the same flag in one cycle, the flag ends in the state given by applying their operations in ascending processor index.
- R10: Operations on different flags in the same cycle all take effect in that cycle, without interfering with one another.
- R11: An operation changes only the flag its processor has selected. In a cycle with no valid operation, no flag changes.
- R12: opCode[p] is ignored while opValid[p] is low. No flag changes and no response is produced.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| selWrEn | input | NUM_PROCS | Per-processor load strobe for the selection register |
| selWrData | input | NUM_PROCS*IDX_W | Per-processor new flag index |
| opValid | input | NUM_PROCS | Per-processor request valid |
| opCode | input | NUM_PROCS*2 | Per-processor operation code |
| rspValid | output | NUM_PROCS | Per-processor response pulse |
| rspBit | output | NUM_PROCS | Per-processor observed flag value |

## Verification
Directed patterns cover four cases. All four processors test-and-set one flag together; the result must be 0,1,1,1, which exposes a broken priority chain or a lost atomic update. SET and CLEAR pairs are issued in both orders on one flag, which separates ascending from descending resolution. A selection load in the same cycle as a request shows whether the old or the new index is used. Simultaneous requests on distinct flags expose cross-talk. Long seeded random runs that mix all opcodes, idle slots, ignored opcodes and selection reloads are compared against a sequential reference model, and each response bit traces back to the flag history.

// File: rtl/sema_pkg.sv
package sema_pkg;

  localparam int OP_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_TEST    = 2'd0,
    OP_SET     = 2'd1,
    OP_CLEAR   = 2'd2,
    OP_TESTSET = 2'd3
  } semaOp_e;

  // per-requester strobes from control to datapath
  typedef struct packed {
    logic act;
    logic doSet;
    logic doClr;
  } flagStrobe_t;

endpackage

// File: rtl/sema_ctrl.sv
module sema_ctrl
  import sema_pkg::*;
#(
  parameter int NUM_PROCS = 4,
  parameter int NUM_FLAGS = 8,
  localparam int IDX_W = $clog2(NUM_FLAGS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_PROCS-1:0]       selWrEn,
  input  logic [NUM_PROCS*IDX_W-1:0] selWrData,
  input  logic [NUM_PROCS-1:0]       opValid,
  input  logic [NUM_PROCS*OP_W-1:0]  opCode,
  output flagStrobe_t                strobes [NUM_PROCS],
  output logic [NUM_PROCS*IDX_W-1:0] selFlat
);

  for (genvar p = 0; p < NUM_PROCS; p++) begin : g_req
    logic [IDX_W-1:0] selQ;
    semaOp_e          opDec;

    // supervisor-loaded flag selection
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        selQ <= '0;
      end else if (selWrEn[p]) begin
        selQ <= selWrData[p*IDX_W +: IDX_W];
      end
    end

    assign selFlat[p*IDX_W +: IDX_W] = selQ;

    always_comb begin
      opDec = semaOp_e'(opCode[p*OP_W +: OP_W]);
      strobes[p].act   = opValid[p];
      strobes[p].doSet = opValid[p] && (opDec == OP_SET || opDec == OP_TESTSET);
      strobes[p].doClr = opValid[p] && (opDec == OP_CLEAR);
    end
  end

endmodule

// File: rtl/sema_datapath.sv
module sema_datapath
  import sema_pkg::*;
#(
  parameter int NUM_PROCS = 4,
  parameter int NUM_FLAGS = 8,
  localparam int IDX_W = $clog2(NUM_FLAGS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  flagStrobe_t                strobes [NUM_PROCS],
  input  logic [NUM_PROCS*IDX_W-1:0] selFlat,
  output logic [NUM_FLAGS-1:0]       flagQ,
  output logic [NUM_PROCS-1:0]       rspValid,
  output logic [NUM_PROCS-1:0]       rspBit
);

  logic [NUM_FLAGS-1:0] flagD;
  logic [NUM_PROCS-1:0] obsBit;
  logic [NUM_PROCS-1:0] actVec;

  // ascending-index serialization of same-cycle requests
  always_comb begin
    logic [NUM_FLAGS-1:0] work;
    logic [IDX_W-1:0]     idx;
    work   = flagQ;
    obsBit = '0;
    actVec = '0;
    for (int p = 0; p < NUM_PROCS; p++) begin
      idx       = selFlat[p*IDX_W +: IDX_W];
      actVec[p] = strobes[p].act;
      if (strobes[p].act) begin
        obsBit[p] = work[idx];
      end
      if (strobes[p].doSet) begin
        work[idx] = 1'b1;
      end else if (strobes[p].doClr) begin
        work[idx] = 1'b0;
      end
    end
    flagD = work;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ    <= '0;
      rspValid <= '0;
      rspBit   <= '0;
    end else begin
      flagQ    <= flagD;
      rspValid <= actVec;
      rspBit   <= obsBit;
    end
  end

endmodule

// File: rtl/sema_interlock.sv
module sema_interlock
  import sema_pkg::*;
#(
  parameter int NUM_PROCS = 4,
  parameter int NUM_FLAGS = 8,
  localparam int IDX_W = $clog2(NUM_FLAGS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_PROCS-1:0]       selWrEn,
  input  logic [NUM_PROCS*IDX_W-1:0] selWrData,
  input  logic [NUM_PROCS-1:0]       opValid,
  input  logic [NUM_PROCS*OP_W-1:0]  opCode,
  output logic [NUM_PROCS-1:0]       rspValid,
  output logic [NUM_PROCS-1:0]       rspBit
);

  flagStrobe_t                strobes [NUM_PROCS];
  logic [NUM_PROCS*IDX_W-1:0] selFlat;
  logic [NUM_FLAGS-1:0]       flagQ;

  sema_ctrl #(
    .NUM_PROCS(NUM_PROCS),
    .NUM_FLAGS(NUM_FLAGS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .selWrEn  (selWrEn),
    .selWrData(selWrData),
    .opValid  (opValid),
    .opCode   (opCode),
    .strobes  (strobes),
    .selFlat  (selFlat)
  );

  sema_datapath #(
    .NUM_PROCS(NUM_PROCS),
    .NUM_FLAGS(NUM_FLAGS)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .selFlat (selFlat),
    .flagQ   (flagQ),
    .rspValid(rspValid),
    .rspBit  (rspBit)
  );

endmodule

// File: rtl/sema_interlock_chk.sv
module sema_interlock_chk
  import sema_pkg::*;
#(
  parameter int NUM_PROCS = 4,
  parameter int NUM_FLAGS = 8,
  localparam int IDX_W = $clog2(NUM_FLAGS)
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [NUM_PROCS-1:0]       selWrEn,
  input logic [NUM_PROCS*IDX_W-1:0] selWrData,
  input logic [NUM_PROCS-1:0]       opValid,
  input logic [NUM_PROCS*OP_W-1:0]  opCode,
  input logic [NUM_PROCS-1:0]       rspValid,
  input logic [NUM_PROCS-1:0]       rspBit,
  input logic [NUM_PROCS*IDX_W-1:0] selFlat,
  input logic [NUM_FLAGS-1:0]       flagQ
);

  localparam int TOP = NUM_PROCS - 1;

  // R7: one response pulse per request, one cycle later
  a_r7_rsp_follows_op: assert property (@(posedge clk) disable iff (!rstN)
    rspValid == ($past(opValid) & {NUM_PROCS{$past(rstN)}}));

  // R7: data bit quiet without a response
  a_r7_rsp_bit_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (rspBit & ~rspValid) == '0);

  // R11: idle cycle leaves every flag alone
  a_r11_idle_flags_hold: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(opValid) == '0) |-> flagQ == $past(flagQ));

  // R8: lowest index sees the flag as it was before the cycle
  a_r8_first_sees_current: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(opValid[0])) |->
      rspBit[0] == $past(flagQ[selFlat[IDX_W-1:0]]));

  // R6: a test-and-set from the last requester always leaves its flag at 1
  a_r6_testset_last_sets: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(opValid[TOP]) &&
     $past(opCode[TOP*OP_W +: OP_W]) == OP_TESTSET) |->
      flagQ[$past(selFlat[TOP*IDX_W +: IDX_W])]);

  for (genvar p = 0; p < NUM_PROCS; p++) begin : g_sel
    // R2: selection register loads the written index
    a_r2_sel_load: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && $past(selWrEn[p])) |->
        selFlat[p*IDX_W +: IDX_W] == $past(selWrData[p*IDX_W +: IDX_W]));
  end

endmodule

bind sema_interlock sema_interlock_chk #(
  .NUM_PROCS(NUM_PROCS),
  .NUM_FLAGS(NUM_FLAGS)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .selWrEn  (selWrEn),
  .selWrData(selWrData),
  .opValid  (opValid),
  .opCode   (opCode),
  .rspValid (rspValid),
  .rspBit   (rspBit),
  .selFlat  (selFlat),
  .flagQ    (flagQ)
);

// File: tb/sema_interlock_test.sv
module sema_interlock_test;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int NF = 8;
  localparam int IW = 3;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [NP-1:0]  selWrEn = '0;
  logic [NP*IW-1:0] selWrData = '0;
  logic [NP-1:0]  opValid = '0;
  logic [NP*2-1:0] opCode = '0;
  logic [NP-1:0]  rspValid;
  logic [NP-1:0]  rspBit;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  logic [NF-1:0] mFlag;
  int            mSel [NP];
  logic [NP-1:0] expV;
  logic [NP-1:0] expB;

  sema_interlock #(.NUM_PROCS(NP), .NUM_FLAGS(NF)) uut (
    .clk(clk), .rstN(rstN), .selWrEn(selWrEn), .selWrData(selWrData),
    .opValid(opValid), .opCode(opCode), .rspValid(rspValid), .rspBit(rspBit)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic nextFlag(input logic cur, input logic [1:0] op);
    case (op)
      2'd1, 2'd3: return 1'b1;
      2'd2:       return 1'b0;
      default:    return cur;
    endcase
  endfunction

  task automatic check(input string tag, input int p, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s proc %0d: actual %0d expected %0d", tag, p, act, exp);
    end
  endtask

  // drive one cycle at a negedge, update model, compare on the next negedge
  task automatic step(input logic [NP-1:0] v, input logic [NP*2-1:0] oc,
                      input logic [NP-1:0] we, input logic [NP*IW-1:0] wd,
                      input string tag);
    opValid = v; opCode = oc; selWrEn = we; selWrData = wd;
    for (int p = 0; p < NP; p++) begin
      expV[p] = v[p];
      expB[p] = 1'b0;
      if (v[p]) begin
        expB[p] = mFlag[mSel[p]];
        mFlag[mSel[p]] = nextFlag(mFlag[mSel[p]], oc[p*2 +: 2]);
      end
    end
    for (int p = 0; p < NP; p++)
      if (we[p]) mSel[p] = int'(wd[p*IW +: IW]);
    @(negedge clk);
    opValid = '0; selWrEn = '0;
    for (int p = 0; p < NP; p++) begin
      check(tag, p, int'(rspValid[p]), int'(expV[p]));
      check(tag, p, int'(rspBit[p]), int'(expB[p]));
    end
  endtask

  function automatic logic [NP*2-1:0] allOp(input logic [1:0] op);
    return {NP{op}};
  endfunction

  function automatic logic [NP*IW-1:0] allSel(input logic [IW-1:0] s);
    return {NP{s}};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    mFlag = '0;
    for (int p = 0; p < NP; p++) mSel[p] = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: no response while in reset
    for (int p = 0; p < NP; p++) check("R1 reset rsp", p, int'(rspValid[p]), 0);
    rstN = 1'b1;
    @(negedge clk);
    step('1, allOp(2'd0), '0, '0, "R1 flags zero after reset");

    // R2: load in same cycle as SET uses old selection 0
    step(4'b0001, allOp(2'd1), 4'b1111, {3'd4, 3'd3, 3'd2, 3'd1}, "R2 old sel same cycle");
    step('1, allOp(2'd0), '0, '0, "R2 new sel active");
    step('0, '0, 4'b1000, {3'd0, 9'd0}, "R2 reload");
    step(4'b1000, allOp(2'd0), '0, '0, "R2 reload observed");

    // R3 R4 R5 on one flag by proc 0
    step(4'b0001, allOp(2'd1), '0, '0, "R3 set");
    step(4'b0001, allOp(2'd0), '0, '0, "R3 R5 test after set");
    step(4'b0001, allOp(2'd0), '0, '0, "R5 test leaves flag");
    step(4'b0001, allOp(2'd2), '0, '0, "R4 clear");
    step(4'b0001, allOp(2'd0), '0, '0, "R4 test after clear");

    // R6 R8: four-way test-and-set on flag 5 -> 0,1,1,1
    step('0, '0, '1, allSel(3'd5), "R6 select 5");
    step('1, allOp(2'd3), '0, '0, "R6 R8 contention");
    step(4'b0001, allOp(2'd0), '0, '0, "R6 flag held");
    step('1, allOp(2'd2), '0, '0, "R8 all clear");

    // R9: order on one flag
    step(4'b0011, {4'd0, 2'd2, 2'd1}, '0, '0, "R9 set then clear");
    step(4'b0100, allOp(2'd0), '0, '0, "R9 result zero");
    step(4'b0011, {4'd0, 2'd1, 2'd2}, '0, '0, "R9 clear then set");
    step(4'b1000, allOp(2'd0), '0, '0, "R9 result one");

    // R10 R11: distinct flags in one cycle
    step('0, '0, '1, {3'd7, 3'd6, 3'd2, 3'd1}, "R10 distinct select");
    step('1, {2'd1, 2'd3, 2'd1, 2'd2}, '0, '0, "R10 mixed distinct");
    step('1, allOp(2'd0), '0, '0, "R10 R11 distinct readback");
    step('0, '0, '1, {3'd0, 3'd3, 3'd4, 3'd5}, "R11 other flags");
    step('1, allOp(2'd0), '0, '0, "R11 untouched flags");

    // R12: opcode without valid
    step('0, allOp(2'd1), '0, '0, "R12 ignored opcode");
    step('1, allOp(2'd0), '0, '0, "R12 flags unchanged");

    // random mix against the reference model
    for (int i = 0; i < 4000; i++) begin
      logic [NP-1:0]    v;
      logic [NP*2-1:0]  oc;
      logic [NP-1:0]    we;
      logic [NP*IW-1:0] wd;
      v  = NP'($urandom);
      oc = (NP*2)'($urandom);
      we = ($urandom % 6 == 0) ? NP'($urandom) : '0;
      wd = (NP*IW)'($urandom);
      if ($urandom % 4 == 0) wd = allSel(IW'($urandom));
      step(v, oc, we, wd, "R7 R8 R9 R10 random");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule